// File: doc/BRIEF.md
# Smart Card Transmit-End Flag Timer

This block generates the transmit-end status flag of a half-duplex smart card serial transmitter. A strobe marks the start of each byte. From that strobe the block counts ticks that arrive at half the elementary time unit (etu). When the count reaches a check point, the flag goes high, but only if the card has not signalled an error and the transmit data register is empty. The check point depends on two mode bits, guard-time mode and block-transfer mode. It falls 2.5 etu after the start in normal mode, 1.5 etu in block mode, and 1.0 etu whenever guard-time mode is on.

Software clears the flag in two ways. The CPU can read the status while the flag is 1 and then write 0 to the data-empty bit. A DMA transfer that loads the transmit data register also clears it. The flag is read-only and comes out of reset at 1. It is also held at 1 while the transmitter is disabled and no error is pending.

Top module: `sc_tend_timer`

## Requirements
- R1: While `tx_en` is 0 and `err_sig` is 0, `tend` is 1 after every clock edge, even if a clear event arrives in the same cycle.
- R2: With `guard_mode`=0 and `block_mode`=0, `tend` rises at the clock edge that samples the 5th `half_tick` after `tx_start`, and not earlier.
- R3: With `guard_mode`=0 and `block_mode`=1, `tend` rises at the edge that samples the 3rd `half_tick` after `tx_start`.
- R4: With `guard_mode`=1, `tend` rises at the edge that samples the 2nd `half_tick` after `tx_start`, whatever `block_mode` is.
- R5: At the check point, `tend` is set only if `err_sig` is 0 and `tdr_empty` is 1. Otherwise it stays 0 and no later tick sets it until a new `tx_start`.
- R6: A CPU write (`cpu_wr`=1) with `cpu_wr_empty`=0 clears `tend` only after an earlier status read (`cpu_rd`=1) that saw `tend`=1. A read made while `tend`=0 does not qualify a write.
- R7: `dma_wr`=1 clears `tend` at the next edge.
- R8: During and right after reset, `tend` is 1.
- R9: A `tx_start` in the middle of a count restarts it from zero.
- R10: Any CPU write uses up the read qualification, including a write of 1. A later write of 0 then has no effect until the flag is read as 1 again.
- R11: If a clear and a timed set fall in the same cycle, `tend` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| err_sig | input | 1 | Error-signal status from the card |
| tdr_empty | input | 1 | Transmit data register empty flag |
| guard_mode | input | 1 | Guard-time mode select |
| block_mode | input | 1 | Block-transfer mode select |
| tx_start | input | 1 | One-cycle strobe at the start of a byte transmission |
| half_tick | input | 1 | One-cycle strobe every half etu |
| cpu_rd | input | 1 | CPU status-read strobe |
| cpu_wr | input | 1 | CPU status-write strobe |
| cpu_wr_empty | input | 1 | Value the CPU writes to the data-empty bit |
| dma_wr | input | 1 | DMA write into the transmit data register |
| tend | output | 1 | Transmit-end flag |

## Verification
Every result is due one clock edge after the stimulus that causes it. This covers the tick that reaches the check point, the clear strobes, a qualifying read, and the idle hold.

The driver changes inputs just after a falling edge and holds them through one rising edge. It then pushes the expected `tend` value into a queue. The monitor pops that entry at the next falling edge, so each comparison sees exactly the one register update that the stimulus caused.

// File: rtl/sc_tend_pkg.sv
package sc_tend_pkg;

   typedef enum logic [1:0] {
      TM_NORMAL = 2'd0,
      TM_BLOCK  = 2'd1,
      TM_GUARD  = 2'd2
   } tend_mode_e;

   // guard-time mode overrides block mode
   function automatic tend_mode_e tm_decode(input logic gm, input logic blk);
      if (gm)
         return TM_GUARD;
      else if (blk)
         return TM_BLOCK;
      else
         return TM_NORMAL;
   endfunction

endpackage

// File: rtl/sc_tend_etu_cnt.sv
module sc_tend_etu_cnt
   import sc_tend_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int T_NORMAL   = 5,
   parameter int T_BLOCK    = 3,
   parameter int T_GUARD    = 2,
   parameter bit LATCH_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic gm,
   input  logic blk,
   output logic hit
);

   localparam int T_MAX = (T_NORMAL > T_BLOCK) ?
                          ((T_NORMAL > T_GUARD) ? T_NORMAL : T_GUARD) :
                          ((T_BLOCK > T_GUARD) ? T_BLOCK : T_GUARD);
   localparam int T_MIN = (T_NORMAL < T_BLOCK) ?
                          ((T_NORMAL < T_GUARD) ? T_NORMAL : T_GUARD) :
                          ((T_BLOCK < T_GUARD) ? T_BLOCK : T_GUARD);

   initial begin
      if (T_MAX >= (1 << CNT_W))
         $error("sc_tend_etu_cnt: threshold does not fit CNT_W");
      if (T_MIN < 1)
         $error("sc_tend_etu_cnt: thresholds must be at least 1");
   end

   tend_mode_e      mode_use;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             active;

   generate
      if (LATCH_MODE) begin : g_latched
         tend_mode_e mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= TM_NORMAL;
            else if (start)
               mode_q <= tm_decode(gm, blk);
         end
         assign mode_use = mode_q;
      end else begin : g_live
         assign mode_use = tm_decode(gm, blk);
      end
   endgenerate

   always_comb begin
      case (mode_use)
         TM_BLOCK: limit = CNT_W'(T_BLOCK);
         TM_GUARD: limit = CNT_W'(T_GUARD);
         default:  limit = CNT_W'(T_NORMAL);
      endcase
   end

   assign hit = active && !start && tick && (cnt == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (hit) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (active && tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt < CNT_W'(T_MAX))) else $error("count past limit"); // R2
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active && cnt == '0)) else $error("start no restart"); // R9
   AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !active) else $error("counter runs after hit"); // R5

endmodule

// File: rtl/sc_tend_clr_qual.sv
module sc_tend_clr_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic flag,
   input  logic wr_stb,
   input  logic wr_val,
   output logic cpu_clr
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (wr_stb)
         armed <= 1'b0;
      else if (rd_stb && flag)
         armed <= 1'b1;
   end

   assign cpu_clr = wr_stb && !wr_val && armed;

   AST_WR_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !armed) else $error("qualification kept"); // R10
   AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(rd_stb && flag)) else $error("arm w/o read"); // R6

endmodule

// File: rtl/sc_tend_timer.sv
module sc_tend_timer #(
   parameter int CNT_W      = 4,
   parameter int T_NORMAL   = 5,
   parameter int T_BLOCK    = 3,
   parameter int T_GUARD    = 2,
   parameter bit LATCH_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic err_sig,
   input  logic tdr_empty,
   input  logic guard_mode,
   input  logic block_mode,
   input  logic tx_start,
   input  logic half_tick,
   input  logic cpu_rd,
   input  logic cpu_wr,
   input  logic cpu_wr_empty,
   input  logic dma_wr,
   output logic tend
);

   logic hit;
   logic cpu_clr;
   logic idle_hold;
   logic clr_any;
   logic set_ok;

   sc_tend_etu_cnt #(
      .CNT_W     (CNT_W),
      .T_NORMAL  (T_NORMAL),
      .T_BLOCK   (T_BLOCK),
      .T_GUARD   (T_GUARD),
      .LATCH_MODE(LATCH_MODE)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .start(tx_start),
      .tick (half_tick),
      .gm   (guard_mode),
      .blk  (block_mode),
      .hit  (hit)
   );

   sc_tend_clr_qual u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (cpu_rd),
      .flag   (tend),
      .wr_stb (cpu_wr),
      .wr_val (cpu_wr_empty),
      .cpu_clr(cpu_clr)
   );

   assign idle_hold = !tx_en && !err_sig;
   assign clr_any   = cpu_clr || dma_wr;
   assign set_ok    = hit && !err_sig && tdr_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tend <= 1'b1;
      else if (idle_hold)
         tend <= 1'b1;
      else if (clr_any)
         tend <= 1'b0;
      else if (set_ok)
         tend <= 1'b1;
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !err_sig) |=> tend) else $error("idle hold lost"); // R1
   AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && (tx_en || err_sig)) |=> !tend) else $error("dma clear lost"); // R7
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr_any && (tx_en || err_sig)) |=> !tend) else $error("set beat clear"); // R11
   AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend) |-> $past(idle_hold || (hit && !err_sig && tdr_empty)))
      else $error("flag rose without cause"); // R5
   AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend) |-> $past(dma_wr || cpu_wr)) else $error("flag fell without clear"); // R6

endmodule

// File: tb/sc_tend_timer_bench.sv
`timescale 1ns/1ps
module sc_tend_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, err_sig = 1'b0, tdr_empty = 1'b1;
   logic guard_mode = 1'b0, block_mode = 1'b0;
   logic tx_start = 1'b0, half_tick = 1'b0;
   logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_wr_empty = 1'b1, dma_wr = 1'b0;
   logic tend;

   typedef struct {
      string tag;
      logic  val;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_tend_timer u_sc_tend_timer (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .err_sig(err_sig),
      .tdr_empty(tdr_empty), .guard_mode(guard_mode), .block_mode(block_mode),
      .tx_start(tx_start), .half_tick(half_tick), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wr_empty(cpu_wr_empty), .dma_wr(dma_wr),
      .tend(tend)
   );

   // monitor: pops one expectation per falling edge
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if (tend !== e.val) begin
            n_fail++;
            $display("FAIL %s: tend=%b expected %b", e.tag, tend, e.val);
         end
      end
   end

   task automatic expect_tend(input string tag, input logic v);
      exp_q.push_back('{tag: tag, val: v});
   endtask

   // one clock cycle of strobes: st, ht, rd, wr, wv, dm
   task automatic drive(input logic st, input logic ht, input logic rd,
                        input logic wr, input logic wv, input logic dm);
      @(negedge clk); #1;
      tx_start = st; half_tick = ht; cpu_rd = rd;
      cpu_wr = wr; cpu_wr_empty = wv; dma_wr = dm;
      @(posedge clk); #1;
      tx_start = 0; half_tick = 0; cpu_rd = 0;
      cpu_wr = 0; cpu_wr_empty = 1; dma_wr = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(0, 1, 0, 0, 1, 0);
   endtask

   task automatic flush;
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R8 reset value
      repeat (2) @(posedge clk); #1;
      expect_tend("R8 in reset", 1'b1);
      @(posedge clk); #1;
      rst_n = 1'b1;
      expect_tend("R8 after reset", 1'b1);
      flush();

      tx_en = 1'b1;
      // R6: read as 1 then write 0 clears
      drive(0, 0, 1, 0, 1, 0); expect_tend("R6 read keeps flag", 1'b1);
      drive(0, 0, 0, 1, 0, 0); expect_tend("R6 qualified clear", 1'b0);

      // R2 normal mode, 5 half ticks with gaps
      drive(1, 0, 0, 0, 1, 0);
      ticks(2);
      drive(0, 0, 0, 0, 1, 0);
      ticks(2); expect_tend("R2 after 4 ticks", 1'b0);
      ticks(1); expect_tend("R2 at 5th tick", 1'b1);
      drive(0, 0, 0, 0, 1, 1); expect_tend("R7 dma clear", 1'b0);

      // R3 block mode
      block_mode = 1'b1;
      drive(1, 0, 0, 0, 1, 0);
      ticks(2); expect_tend("R3 after 2 ticks", 1'b0);
      ticks(1); expect_tend("R3 at 3rd tick", 1'b1);
      drive(0, 0, 0, 0, 1, 1);

      // R4 guard mode, both block settings
      guard_mode = 1'b1; block_mode = 1'b0;
      drive(1, 0, 0, 0, 1, 0);
      ticks(1); expect_tend("R4 gm blk0 after 1", 1'b0);
      ticks(1); expect_tend("R4 gm blk0 at 2nd", 1'b1);
      drive(0, 0, 0, 0, 1, 1);
      block_mode = 1'b1;
      drive(1, 0, 0, 0, 1, 0);
      ticks(1); expect_tend("R4 gm blk1 after 1", 1'b0);
      ticks(1); expect_tend("R4 gm blk1 at 2nd", 1'b1);
      drive(0, 0, 0, 0, 1, 1);
      guard_mode = 1'b0; block_mode = 1'b0;

      // R5 gating by error and data-empty
      err_sig = 1'b1;
      drive(1, 0, 0, 0, 1, 0);
      ticks(5); expect_tend("R5 error blocks set", 1'b0);
      err_sig = 1'b0;
      ticks(3); expect_tend("R5 no late set", 1'b0);
      tdr_empty = 1'b0;
      drive(1, 0, 0, 0, 1, 0);
      ticks(5); expect_tend("R5 tdr full blocks set", 1'b0);
      tdr_empty = 1'b1;

      // R9 restart mid count
      drive(1, 0, 0, 0, 1, 0);
      ticks(3);
      drive(1, 0, 0, 0, 1, 0);
      ticks(3); expect_tend("R9 restarted count", 1'b0);
      ticks(2); expect_tend("R9 set after restart", 1'b1);

      // R6 write 0 without read does nothing
      drive(0, 0, 0, 1, 0, 0); expect_tend("R6 unqualified write", 1'b1);
      // R10 write of 1 consumes qualification
      drive(0, 0, 1, 0, 1, 0);
      drive(0, 0, 0, 1, 1, 0); expect_tend("R10 write 1", 1'b1);
      drive(0, 0, 0, 1, 0, 0); expect_tend("R10 consumed", 1'b1);
      drive(0, 0, 1, 0, 1, 0);
      drive(0, 0, 0, 1, 0, 0); expect_tend("R6 requalified clear", 1'b0);
      // R6 read while flag 0 does not qualify
      drive(0, 0, 1, 0, 1, 0);
      drive(1, 0, 0, 0, 1, 0);
      ticks(5); expect_tend("R2 set again", 1'b1);
      drive(0, 0, 0, 1, 0, 0); expect_tend("R6 stale read", 1'b1);
      drive(0, 0, 0, 0, 1, 1);

      // R11 clear wins over timed set
      drive(1, 0, 0, 0, 1, 0);
      ticks(4);
      drive(0, 1, 0, 0, 1, 1); expect_tend("R11 clear wins", 1'b0);

      // R1 idle hold beats clears
      tx_en = 1'b0;
      drive(0, 0, 0, 0, 1, 0); expect_tend("R1 idle hold", 1'b1);
      drive(0, 0, 0, 0, 1, 1); expect_tend("R1 hold over dma", 1'b1);
      err_sig = 1'b1;
      drive(0, 0, 0, 0, 1, 1); expect_tend("R7 clear with error", 1'b0);

      flush();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule